// File: doc/BRIEF.md
# Isolated-Channel Pulse Decoder with Starvation Watchdog

This block is the receiving end of one channel that crosses an isolation barrier. The far side sends two kinds of short pulses on separate wires. One kind means "drive the line high" and the other means "drive the line low". The sender also repeats the current level as refresh pulses while the data is idle. The decoder brings both pulse wires into the local clock domain through a synchronizer chain. It turns each low-to-high transition into a one-cycle event and keeps the decoded level in a set/clear register that holds until the next event.

A watchdog counts the clock cycles since the last event of either kind. When the count reaches its limit, the sender is treated as lost: the output is forced to the safe low state and a link-fault flag is raised. The first pulse that arrives afterwards clears the flag and sets the level again. If both pulse kinds are seen in the same cycle, the level is left unchanged and a sticky protocol-error flag records the event. The watchdog limit is a parameter in clock cycles. It must be longer than the sender's refresh interval.

Top module: `pulse_rx_decoder`

## Requirements
- R1: A low-to-high transition on a pulse input changes `level_o` at the third rising clock edge at which that input is sampled high. The input passes through two synchronizer flops and then an edge register.
- R2: A high-pulse event alone sets `level_o` to 1 and a low-pulse event alone sets it to 0. Between events the level holds.
- R3: The link fault is raised when `TIMEOUT_CYC` rising edges pass with no event after the edge that applied the last event. At the next edge `link_fault_o` becomes 1 and `level_o` becomes 0.
- R4: While `link_fault_o` is 1, `level_o` is 0.
- R5: When both events occur in the same cycle, `level_o` keeps its value and `proto_err_o` becomes 1. It stays 1 until reset.
- R6: The first event after a fault clears `link_fault_o` on the same edge that applies that event's level.
- R7: While `rst` is high and right after it is released, `level_o`=0, `link_fault_o`=1 and `proto_err_o`=0.
- R8: An input held high produces a single event. Only its low-to-high transition counts.
- R9: Every event restarts the watchdog, including refresh pulses that repeat the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_pulse_i | input | 1 | Asynchronous pulse asking for a high level |
| lo_pulse_i | input | 1 | Asynchronous pulse asking for a low level |
| level_o | output | 1 | Decoded, held channel level |
| link_fault_o | output | 1 | High while the sender is considered lost |
| proto_err_o | output | 1 | Sticky flag: both pulse kinds were seen in one cycle |

## Verification
Several input patterns are used, and each separates different behaviours.
- Isolated single-cycle and multi-cycle pulses of each kind pin the latency exactly. They also show whether the level depends only on transitions or on how long an input stays high.
- Refresh pulses that repeat the present level, sent at intervals just below the limit, show whether repeats restart the watchdog without disturbing the output.
- Silences exactly at the limit, and one cycle past it, locate the timeout edge.
- Coincident pulses of both kinds separate a correct hold from a level taken from either input.
- A long random mix of these patterns is checked cycle by cycle against a model built from the requirements.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int unsigned NUM_KINDS = 2;
  localparam int unsigned KIND_HI   = 0;
  localparam int unsigned KIND_LO   = 1;

  typedef struct packed {
    logic hi;
    logic lo;
  } pulse_ev_t;
endpackage

// File: rtl/pdec_edge_sync.sv
module pdec_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~prev;

  // R8: an edge event lasts exactly one cycle
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pdec_watchdog.sv
module pdec_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= LIMIT;
    else if (kick_i)       cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == LIMIT);

  // R3: the count never runs past its limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
  // R9: a kick always leaves the watchdog unexpired
  p_kick_restart_r9: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> !expired_o);
endmodule

// File: rtl/pdec_level_reg.sv
module pdec_level_reg
  import pdec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pulse_ev_t ev_i,
  input  logic      expired_i,
  output logic      level_o,
  output logic      fault_o,
  output logic      err_o
);
  logic any_ev;
  assign any_ev = ev_i.hi | ev_i.lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b0;
      fault_o <= 1'b1;
      err_o   <= 1'b0;
    end else if (any_ev) begin
      fault_o <= 1'b0;
      if (ev_i.hi && ev_i.lo) err_o   <= 1'b1;
      else                    level_o <= ev_i.hi;
    end else if (expired_i) begin
      fault_o <= 1'b1;
      level_o <= 1'b0;
    end
  end

  // R4: fault implies a low output
  p_fault_low_r4: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !level_o);
  // R2: a lone high event yields a high output
  p_hi_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_i.hi && !ev_i.lo) |=> level_o);
  // R2: a lone low event yields a low output
  p_lo_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_i.lo && !ev_i.hi) |=> !level_o);
  // R5: coincident events hold the level and flag an error
  p_both_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_i.hi && ev_i.lo) |=> (level_o == $past(level_o)) && err_o);
  // R5: the error flag is sticky
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  // R6: any event clears the fault
  p_event_clears_r6: assert property (@(posedge clk) disable iff (rst)
    any_ev |=> !fault_o);
endmodule

// File: rtl/pulse_rx_decoder.sv
module pulse_rx_decoder
  import pdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_pulse_i,
  input  logic lo_pulse_i,
  output logic level_o,
  output logic link_fault_o,
  output logic proto_err_o
);
  logic [NUM_KINDS-1:0] raw;
  logic [NUM_KINDS-1:0] rise;
  pulse_ev_t            ev;
  logic                 wd_expired;

  assign raw[KIND_HI] = hi_pulse_i;
  assign raw[KIND_LO] = lo_pulse_i;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_sync
    pdec_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (raw[k]),
      .rise_o  (rise[k])
    );
  end

  assign ev.hi = rise[KIND_HI];
  assign ev.lo = rise[KIND_LO];

  pdec_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .kick_i    (ev.hi | ev.lo),
    .expired_o (wd_expired)
  );

  pdec_level_reg u_lvl (
    .clk       (clk),
    .rst       (rst),
    .ev_i      (ev),
    .expired_i (wd_expired),
    .level_o   (level_o),
    .fault_o   (link_fault_o),
    .err_o     (proto_err_o)
  );

  // R3: timeout without an event raises the fault and drops the level
  p_timeout_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (wd_expired && !(ev.hi || ev.lo)) |=> link_fault_o && !level_o);
endmodule

// File: tb/tb_pulse_rx_decoder.sv
module tb_pulse_rx_decoder;
  localparam int TO = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_i = 1'b0, lo_i = 1'b0;
  logic level, fault, perr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_rx_decoder #(.SYNC_STAGES(2), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst(rst), .hi_pulse_i(hi_i), .lo_pulse_i(lo_i),
    .level_o(level), .link_fault_o(fault), .proto_err_o(perr)
  );

  // requirement-level model
  bit a1, a2, a3, b1, b2, b3;
  bit m_lvl, m_flt, m_err;
  int m_idle;

  function automatic void model_reset();
    a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0;
    m_lvl = 0; m_flt = 1; m_err = 0; m_idle = TO;
  endfunction

  function automatic void model_step(bit h, bit l);
    bit eh, el;
    eh = a2 & ~a3;
    el = b2 & ~b3;
    if (eh || el) begin
      m_flt = 0;
      m_idle = 0;
      if (eh && el) m_err = 1;
      else m_lvl = eh;
    end else begin
      if (m_idle >= TO) begin
        m_flt = 1;
        m_lvl = 0;
      end
      if (m_idle < TO) m_idle++;
    end
    a3 = a2; a2 = a1; a1 = h;
    b3 = b2; b2 = b1; b1 = l;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit h, input bit l);
    hi_i = h; lo_i = l;
    @(posedge clk);
    if (rst) model_reset(); else model_step(h, l);
    @(negedge clk);
    chk("R2 level", level, m_lvl);
    chk("R3 fault", fault, m_flt);
    chk("R5 perr", perr, m_err);
  endtask

  task automatic pulse(input bit h, input bit l, input int w);
    for (int i = 0; i < w; i++) tick(h, l);
    tick(0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    model_reset();
    @(negedge clk);
    tick(0, 0); tick(0, 0);
    chk("R7 reset level", level, 1'b0);
    chk("R7 reset fault", fault, 1'b1);
    chk("R7 reset perr", perr, 1'b0);
    rst = 1'b0;
    tick(0, 0);
    chk("R7 post-reset fault", fault, 1'b1);

    // R1 exact latency, R6 clear on first event
    tick(1, 0);
    chk("R1 after 1 edge", level, 1'b0);
    tick(1, 0);
    chk("R1 after 2 edges", level, 1'b0);
    chk("R6 fault before apply", fault, 1'b1);
    tick(0, 0);
    chk("R1 after 3 edges", level, 1'b1);
    chk("R6 fault cleared", fault, 1'b0);

    // R3 boundary: event applied at the last edge, TO silent edges
    idle(TO);
    chk("R3 fault at limit", fault, 1'b0);
    chk("R3 level at limit", level, 1'b1);
    tick(0, 0);
    chk("R3 fault past limit", fault, 1'b1);
    chk("R4 level low in fault", level, 1'b0);
    idle(5);
    chk("R4 level stays low", level, 1'b0);

    // R9 refresh pulses at intervals below the limit keep the link up
    pulse(1, 0, 1); idle(2);
    for (int i = 0; i < 4; i++) begin
      idle(TO - 6);
      pulse(1, 0, 2);
      chk("R9 refresh keeps link", fault, 1'b0);
      chk("R9 refresh keeps level", level, 1'b1);
    end

    // R8 held input is one event: clear, then hold high across timeout
    pulse(0, 1, 1); idle(2);
    chk("R2 low pulse", level, 1'b0);
    for (int i = 0; i < TO + 8; i++) tick(1, 0);
    chk("R8 held input no refresh", fault, 1'b1);
    chk("R8 held input level", level, 1'b0);
    tick(0, 0);

    // R5 coincident pulses
    pulse(1, 0, 1); idle(2);
    pulse(1, 1, 1); idle(2);
    chk("R5 hold level", level, 1'b1);
    chk("R5 error set", perr, 1'b1);
    pulse(0, 1, 1); idle(2);
    chk("R5 error sticky", perr, 1'b1);
    chk("R2 low after error", level, 1'b0);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      r = $urandom % 100;
      if (r < 6)       idle(TO + ($urandom % 6));
      else if (r < 40) pulse(1, 0, 1 + ($urandom % 3));
      else if (r < 74) pulse(0, 1, 1 + ($urandom % 3));
      else if (r < 77) pulse(1, 1, 1);
      else             idle($urandom % (TO - 4));
    end

    // reset in mid-run
    rst = 1'b1; tick(0, 0); tick(0, 0);
    chk("R7 rerun perr cleared", perr, 1'b0);
    chk("R7 rerun fault", fault, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule